// File: doc/BRIEF.md
# Serial Word Receiver with In-Band Framing

This block rebuilds 12-bit parallel words from a serial data line and the bit clock that travels beside it. No separate frame line exists: a word start is marked by a data transition while the bit clock is high, whereas ordinary data bits only change while the bit clock is low. After such a mark, the next twelve rising bit-clock edges each sample one data bit, least significant bit first. The finished word is presented on a parallel output together with an active-low word strobe.

Both serial inputs cross into a single oversampling system clock, which must run at least four times the bit rate, through multi-stage synchronizers. All edge detection works on the synchronized copies. The transmitter may send spare filler bits between words when its bit clock runs faster than its word rate. The receiver discards these bits. The strobe has a fixed low time of about seven bit times, and its high time stretches to fill the rest of each word period. A direction input selects receive mode when low. In receive mode the block reports that the transmit path is idle.

Top module: `sdes_rx`

## Requirements
- R1: While `dir_i` is low the block receives and `tx_en_o` is low. While `dir_i` is high, `tx_en_o` is high.
- R2: A word start is a change of the synchronized data level while the synchronized bit clock is high on both the current and the previous system cycle. The next 12 rising bit-clock edges each sample one data bit. The first bit sampled becomes bit 0 of `par_dat_o`, and the last becomes bit 11.
- R3: Bits that arrive after the 12th bit of a word and before the next word start are ignored. They neither produce a strobe nor change `par_dat_o`.
- R4: `par_dat_o` changes only in the system cycle in which `wstb_n_o` falls. `wstb_n_o` falls once for each completed word.
- R5: After each fall, `wstb_n_o` stays low for exactly `STB_LOW_CYC` system cycles (default 56) and then stays high until the next completed word.
- R6: A bit stream that contains no word start produces no strobe pulse. In that case `wstb_n_o` stays high and `par_dat_o` holds its value.
- R7: A word start that arrives before 12 bits have been collected abandons the partial word without a strobe. The 12 bits that follow it form the next word.
- R8: While `dir_i` is high, `wstb_n_o` is high, `par_dat_o` holds its value, and serial activity does not complete a word.
- R9: During reset and after it, `par_dat_o` is zero and `wstb_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_i | input | 1 | Direction select; low enables receive |
| ser_clk_i | input | 1 | Forwarded serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| par_dat_o | output | 12 | Received parallel word |
| wstb_n_o | output | 1 | Active-low word strobe |
| tx_en_o | output | 1 | High while the transmit path may run |

## Verification
The checker verifies four things on every cycle:
- the parallel word never changes except in the cycle where the strobe falls;
- the strobe low time is exactly the configured count;
- the strobe stays high while transmit direction is selected;
- the output holds while transmit direction is selected.

Only the bench scenarios can show the following:
- bits are assembled in the right order;
- filler bits are ignored;
- an interrupted word is abandoned;
- a stream with no framing mark produces nothing.

These need a known serial input compared against a word that was computed independently.

// File: rtl/sdes_pkg.sv
// Shared types for the serial word receiver.
// Assumes: none; pure type definitions.
package sdes_pkg;

    // Per-cycle events extracted from the synchronized serial lines.
    typedef struct packed {
        logic start;    // framing mark: data moved while bit clock high
        logic rise;     // rising edge of the bit clock
        logic bit_val;  // synchronized data level this cycle
    } sdes_evt_t;

endpackage

// File: rtl/sdes_sync.sv
// Multi-stage synchronizer for one asynchronous single-bit signal.
// Assumes: STAGES >= 2; the input is sampled by clk with no timing relation.
module sdes_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the sampled level one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else if (g == 0) begin
                    chain[g] <= d_i;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sdes_frame_det.sv
// Finds bit-clock rising edges and framing marks on the synchronized lines.
// Assumes: both inputs pass through synchronizers of equal depth, so that
// a data change made while the bit clock is low never appears to fall
// inside a high phase.
module sdes_frame_det
    import sdes_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_clk_i,
    input  logic      s_dat_i,
    output sdes_evt_t evt_o
);
    logic clk_d;
    logic dat_d;

    // Keep the previous cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            dat_d <= 1'b0;
        end else begin
            clk_d <= s_clk_i;
            dat_d <= s_dat_i;
        end
    end

    // Classify the current cycle.
    always_comb begin
        evt_o.start   = s_clk_i && clk_d && (s_dat_i != dat_d);
        evt_o.rise    = s_clk_i && !clk_d;
        evt_o.bit_val = s_dat_i;
    end
endmodule

// File: rtl/sdes_shift.sv
// Collects WORD_W bits after each framing mark, LSB first.
// Assumes: en is quasi-static in the clk domain. A start and a rise never
// coincide, because a start needs the clock high on two cycles.
// Outputs the completed word combinationally with a one-cycle done flag.
module sdes_shift
    import sdes_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  sdes_evt_t         evt_i,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              busy;
    logic              take;

    assign take   = en_i && busy && evt_i.rise;
    assign word_o = {evt_i.bit_val, shreg[WORD_W-1:1]};
    assign done_o = take && (cnt == CNT_W'(WORD_W-1));

    // Track the word in progress: restart on a mark, shift on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
        end else if (!en_i) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (evt_i.start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (take) begin
            shreg <= word_o;
            if (done_o) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdes_outstage.sv
// Registers the parallel word and shapes the active-low strobe.
// Assumes: words arrive farther apart than STB_LOW_CYC cycles. A new word
// that arrives earlier restarts the low time.
module sdes_outstage #(
    parameter int WORD_W      = 12,
    parameter int STB_LOW_CYC = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] par_o,
    output logic              stb_n_o
);
    localparam int LOW_W = $clog2(STB_LOW_CYC + 1);

    logic [LOW_W-1:0] low_cnt;

    // Latch the word and drop the strobe together, then time the low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_o   <= '0;
            stb_n_o <= 1'b1;
            low_cnt <= '0;
        end else if (!en_i) begin
            stb_n_o <= 1'b1;
            low_cnt <= '0;
        end else if (load_i) begin
            par_o   <= word_i;
            stb_n_o <= 1'b0;
            low_cnt <= LOW_W'(STB_LOW_CYC - 1);
        end else if (!stb_n_o) begin
            if (low_cnt == '0) begin
                stb_n_o <= 1'b1;
            end else begin
                low_cnt <= low_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdes_rx.sv
// Serial word receiver top: synchronizers, framing detection, shifting and
// output staging. Assumes clk runs at least 4x the serial bit rate, and
// that dir_i is synchronous to clk.
module sdes_rx
    import sdes_pkg::*;
#(
    parameter int WORD_W      = 12,
    parameter int STB_LOW_CYC = 56,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_i,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    output logic [WORD_W-1:0] par_dat_o,
    output logic              wstb_n_o,
    output logic              tx_en_o
);
    logic              s_clk;
    logic              s_dat;
    logic              rx_en;
    sdes_evt_t         evt;
    logic [WORD_W-1:0] word;
    logic              done;

    assign rx_en   = !dir_i;
    assign tx_en_o = dir_i;

    sdes_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d_i(ser_clk_i), .q_o(s_clk)
    );

    sdes_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d_i(ser_dat_i), .q_o(s_dat)
    );

    sdes_frame_det u_det (
        .clk(clk), .rst_n(rst_n), .s_clk_i(s_clk), .s_dat_i(s_dat), .evt_o(evt)
    );

    sdes_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en), .evt_i(evt),
        .word_o(word), .done_o(done)
    );

    sdes_outstage #(.WORD_W(WORD_W), .STB_LOW_CYC(STB_LOW_CYC)) u_out (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en), .load_i(done),
        .word_i(word), .par_o(par_dat_o), .stb_n_o(wstb_n_o)
    );
endmodule

// File: rtl/sdes_rx_chk.sv
// Protocol checker for sdes_rx, attached with bind.
// Assumes: it observes only the ports of the top module.
module sdes_rx_chk #(
    parameter int WORD_W      = 12,
    parameter int STB_LOW_CYC = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_i,
    input logic [WORD_W-1:0] par_dat_o,
    input logic              wstb_n_o
);
    localparam int RUN_W = $clog2(STB_LOW_CYC + 2) + 1;

    logic [RUN_W-1:0] low_run;

    // Count consecutive low strobe cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || wstb_n_o) begin
            low_run <= '0;
        end else if (low_run != {RUN_W{1'b1}}) begin
            low_run <= low_run + 1'b1;
        end
    end

    p_data_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(par_dat_o) |-> $fell(wstb_n_o));

    p_low_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wstb_n_o) |-> (low_run == RUN_W'(STB_LOW_CYC)));

    p_strobe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dir_i) |-> wstb_n_o);

    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dir_i) |-> $stable(par_dat_o));
endmodule

bind sdes_rx sdes_rx_chk #(.WORD_W(WORD_W), .STB_LOW_CYC(STB_LOW_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i),
    .par_dat_o(par_dat_o), .wstb_n_o(wstb_n_o)
);

// File: tb/sdes_rx_tb_top.sv
// Self-checking bench for sdes_rx.
module sdes_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 4;   // system cycles per bit-clock half period
    localparam int LOW_EXP    = 56;
    localparam int NVEC       = 6;
    // {word[11:0], filler bit count[7:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {12'hA5C, 8'd0}, {12'h001, 8'd3}, {12'h800, 8'd7},
        {12'hFFF, 8'd1}, {12'h000, 8'd10}, {12'h3C6, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_i = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic [11:0] par_dat;
    logic        wstb_n;
    logic        tx_en;

    int n_chk = 0;
    int n_fail = 0;
    int n_stb = 0;
    int exp_stb = 0;
    int low_run = 0;
    int last_low = 0;
    logic [11:0] last_word = '0;
    logic        prev_stb = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdes_rx dut_i (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
        .par_dat_o(par_dat), .wstb_n_o(wstb_n), .tx_en_o(tx_en)
    );

    // Monitor strobe falls and low widths away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stb && !wstb_n) begin
                n_stb++;
                last_word = par_dat;
            end
            if (!wstb_n) low_run++;
            else if (!prev_stb) begin
                last_low = low_run;
                low_run = 0;
            end
            prev_stb = wstb_n;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_clk = 1'b0; ser_dat = b; tick(HB);
        ser_clk = 1'b1; tick(HB);
    endtask

    task automatic mark();
        ser_clk = 1'b0; tick(HB);
        ser_clk = 1'b1; tick(2);
        ser_dat = ~ser_dat; tick(HB - 2);
    endtask

    task automatic send_word(input logic [11:0] w);
        mark();
        for (int i = 0; i < 12; i++) send_bit(w[i]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        chk(par_dat == 12'h000, "R9 word in reset", par_dat, 0);
        chk(wstb_n == 1'b1, "R9 strobe in reset", wstb_n, 1);
        rst_n = 1'b1;
        tick(3);
        chk(wstb_n == 1'b1 && par_dat == 0, "R9 after reset", {wstb_n, par_dat}, 13'h1000);
        chk(tx_en == 1'b0, "R1 tx idle in receive", tx_en, 0);

        // Table walk: words with filler bits between them (R2, R3, R4, R5).
        for (int v = 0; v < NVEC; v++) begin
            send_word(VEC[v][19:8]);
            for (int f = 0; f < int'(VEC[v][7:0]); f++) send_bit(f[0] ^ v[0]);
            tick(70);
            exp_stb++;
            chk(n_stb == exp_stb, "R3/R4 one strobe per word", n_stb, exp_stb);
            chk(last_word == VEC[v][19:8], "R2 word LSB first", last_word, VEC[v][19:8]);
            chk(last_low == LOW_EXP, "R5 strobe low width", last_low, LOW_EXP);
            chk(par_dat == VEC[v][19:8], "R3 filler leaves word", par_dat, VEC[v][19:8]);
        end

        // R6: bits with no framing mark.
        for (int i = 0; i < 20; i++) send_bit(i[1]);
        tick(70);
        chk(n_stb == exp_stb, "R6 no strobe without mark", n_stb, exp_stb);
        chk(wstb_n == 1'b1, "R6 strobe stays high", wstb_n, 1);
        chk(par_dat == VEC[NVEC-1][19:8], "R6 word held", par_dat, VEC[NVEC-1][19:8]);

        // R7: interrupted word is abandoned, the next one is received.
        mark();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_word(12'h5A3);
        tick(70);
        exp_stb++;
        chk(n_stb == exp_stb, "R7 single strobe after abort", n_stb, exp_stb);
        chk(last_word == 12'h5A3, "R7 fresh word", last_word, 12'h5A3);

        // R8: transmit direction blocks reception.
        dir_i = 1'b1;
        tick(2);
        chk(tx_en == 1'b1, "R1 tx enabled when dir high", tx_en, 1);
        send_word(12'h0F0);
        tick(70);
        chk(n_stb == exp_stb, "R8 no strobe when disabled", n_stb, exp_stb);
        chk(par_dat == 12'h5A3, "R8 word held when disabled", par_dat, 12'h5A3);
        dir_i = 1'b0;
        tick(2);
        send_word(12'h9E1);
        tick(70);
        exp_stb++;
        chk(last_word == 12'h9E1, "R1 receive resumes", last_word, 12'h9E1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule